// File: doc/BRIEF.md
# I2C serial memory slave engine

This block is the synchronous slave-side protocol engine of a byte-addressed serial memory on a two-wire bus. It runs on a fast system clock, passes the bus clock and data lines through two-flop synchronizers and finds their edges. From those edges it recognises START and STOP conditions and decodes the device-select byte against three strap pins. It loads a 13-bit address into an internal address counter and serves byte writes, random reads, current-address reads and sequential reads. The bus data line is driven through an active-high "pull low" enable, so the pad is open drain.

A write is held in a one-byte buffer until the master issues STOP. STOP then commits the byte and starts a self-timed programming cycle. While that cycle runs the engine refuses every device-select byte, so the master can poll for completion. A behavioural register array stands in for the non-volatile store. It keeps 2^STORE_AW bytes, indexed by the low bits of the 13-bit address, so higher addresses alias onto it.

Top module: `serial_mem_slave`

## Requirements
- R1: A START (data falls while clock is high) or a STOP (data rises while clock is high) aborts any transfer in progress. After a STOP the engine is idle and answers the next START with a fresh select decode.
- R2: A select byte of 1010 in bits 7..4, the strap pins in bits 3..1 and the direction in bit 0 (1 = read) is acknowledged by holding data low through the ninth clock, provided no programming cycle is running.
- R3: A select byte whose upper nibble or strap field does not match is not acknowledged. The engine leaves the line released and ignores every later byte until the next START.
- R4: After a write select, the next byte gives address bits 12..8 in its low five bits and the byte after it gives bits 7..0. Both bytes are acknowledged and loaded into the address counter.
- R5: Each data byte after the address is acknowledged, buffered together with the current counter value, and the counter then advances by one. A STOP after data writes the last buffered byte to its address and starts a busy cycle of PROG_CYCLES system clocks.
- R6: A repeated START after the address phase, or after data, drops the buffered byte without programming. A read select that follows returns the byte at the loaded address (random read).
- R7: A read select with no address phase returns the byte at the counter's current value. The counter advances by one for every byte sent.
- R8: Reading continues while the master acknowledges each byte. A master no-acknowledge releases the line until STOP. The counter wraps from 8191 to 0.
- R9: While the programming cycle runs, select bytes of both directions are refused. Once the cycle has finished, select bytes are acknowledged again.
- R10: Incoming bits are taken on the synchronized clock rising edge. Outgoing bits go most significant bit first, and the pull-low enable changes only while the synchronized clock is low.
- R11: After reset the line is released, the engine is idle, the counter is 0 and the store holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| csPins | input | 3 | Strap pins compared with select bits 3..1 |
| sdaPullLow | output | 1 | High to pull the data line low (open-drain enable) |

## Verification
The assertions check on every cycle that the pull-low enable moves only while the synchronized clock is low, that an ignored transfer never drives the line, and that a STOP always lands in idle. They also check that a commit raises busy, that busy never meets an acknowledge of a select byte, and that a read at the top address wraps the counter to zero. What only the bench scenarios can show is end-to-end: data written through the bus comes back at the right address, random, current and wrapping sequential reads return the right bytes in order, a dropped write leaves the store untouched, and polling is refused and then accepted across a programming cycle.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
package smem_pkg;

  // fixed device-type nibble carried in select bits 7..4
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_IGNORE
  } busState_t;

  // strobes from the control FSM to the datapath and store
  typedef struct packed {
    logic clrBit;   // restart bit counting
    logic loadHi;   // load high address bits from received byte
    logic loadLo;   // load low address bits from received byte
    logic loadTx;   // fetch byte at counter into tx shifter, advance counter
    logic shiftTx;  // move next outgoing bit into place
    logic capWr;    // buffer received data byte, advance counter
    logic dropWr;   // discard buffered byte
    logic commit;   // program buffered byte, start busy cycle
  } dpStrobe_t;

endpackage

// File: rtl/smem_datapath.sv
`timescale 1ns/1ps
module smem_datapath
  import smem_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int STORE_AW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  dpStrobe_t           stb,
  input  logic [7:0]          memRdata,
  output logic                startEv,
  output logic                stopEv,
  output logic                sclFall,
  output logic                sclSync,
  output logic [3:0]          bitCnt,
  output logic [7:0]          rxByte,
  output logic                txNext,
  output logic [STORE_AW-1:0] memIdx,
  output logic                wrValid,
  output logic [STORE_AW-1:0] wrIdx,
  output logic [7:0]          wrData
);

  localparam int HI_W = ADDR_W - 8;

  logic sclMeta, sclS, sclD;
  logic sdaMeta, sdaS, sdaD;
  logic sclRise;
  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic [ADDR_W-1:0] addrCnt;

  // two-flop synchronizers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1; sclS <= 1'b1; sclD <= 1'b1;
      sdaMeta <= 1'b1; sdaS <= 1'b1; sdaD <= 1'b1;
    end else begin
      sclMeta <= sclIn; sclS <= sclMeta; sclD <= sclS;
      sdaMeta <= sdaIn; sdaS <= sdaMeta; sdaD <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
  assign sclSync = sclS;

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else begin
      if (sclRise) rxShift <= {rxShift[6:0], sdaS};
      if (stb.clrBit) bitCnt <= '0;
      else if (sclRise && bitCnt != 4'hF) bitCnt <= bitCnt + 4'd1;
    end
  end

  assign rxByte = rxShift;

  // address counter: loads from the address bytes, advances per data byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else begin
      if (stb.loadHi) addrCnt[ADDR_W-1:8] <= rxShift[HI_W-1:0];
      if (stb.loadLo) addrCnt[7:0] <= rxShift;
      if (stb.loadTx || stb.capWr) addrCnt <= addrCnt + 1'b1;
    end
  end

  assign memIdx = addrCnt[STORE_AW-1:0];

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '0;
    else if (stb.loadTx) txShift <= memRdata;
    else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
  end

  assign txNext = txShift[6];

  // one-byte write buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrIdx   <= '0;
      wrData  <= '0;
    end else if (stb.capWr) begin
      wrValid <= 1'b1;
      wrIdx   <= addrCnt[STORE_AW-1:0];
      wrData  <= rxShift;
    end else if (stb.dropWr || stb.commit) begin
      wrValid <= 1'b0;
    end
  end

  // R8
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && !stb.loadHi && !stb.loadLo && addrCnt == {ADDR_W{1'b1}}) |=> addrCnt == '0);

endmodule

// File: rtl/smem_ctrl.sv
`timescale 1ns/1ps
module smem_ctrl
  import smem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sclFall,
  input  logic       sclSync,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic       txNext,
  input  logic       memRdMsb,
  input  logic       wrValid,
  input  logic       busy,
  input  logic [2:0] csPins,
  output dpStrobe_t  stb,
  output logic       sdaOe
);

  busState_t state, stNext;
  logic oeNext;
  logic rdMode, rdNext;
  logic selMatch;

  assign selMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == csPins) && !busy;

  always_comb begin
    stb    = '0;
    stNext = state;
    oeNext = sdaOe;
    rdNext = rdMode;
    if (startEv) begin
      stNext     = ST_DEV;
      stb.clrBit = 1'b1;
      stb.dropWr = 1'b1;
    end else if (stopEv) begin
      stNext     = ST_IDLE;
      stb.commit = wrValid;
    end else if (sclFall) begin
      case (state)
        ST_DEV: if (bitCnt == 4'd8) begin
          if (selMatch) begin
            oeNext = 1'b1;
            rdNext = rxByte[0];
            stNext = ST_DEV_ACK;
          end else begin
            oeNext = 1'b0;
            stNext = ST_IGNORE;
          end
        end
        ST_DEV_ACK: begin
          stb.clrBit = 1'b1;
          if (rdMode) begin
            stb.loadTx = 1'b1;
            oeNext     = ~memRdMsb;
            stNext     = ST_RDAT;
          end else begin
            oeNext = 1'b0;
            stNext = ST_AHI;
          end
        end
        ST_AHI: if (bitCnt == 4'd8) begin
          stb.loadHi = 1'b1;
          oeNext     = 1'b1;
          stNext     = ST_AHI_ACK;
        end
        ST_AHI_ACK: begin
          stb.clrBit = 1'b1;
          oeNext     = 1'b0;
          stNext     = ST_ALO;
        end
        ST_ALO: if (bitCnt == 4'd8) begin
          stb.loadLo = 1'b1;
          oeNext     = 1'b1;
          stNext     = ST_ALO_ACK;
        end
        ST_ALO_ACK: begin
          stb.clrBit = 1'b1;
          oeNext     = 1'b0;
          stNext     = ST_WDAT;
        end
        ST_WDAT: if (bitCnt == 4'd8) begin
          stb.capWr = 1'b1;
          oeNext    = 1'b1;
          stNext    = ST_WDAT_ACK;
        end
        ST_WDAT_ACK: begin
          stb.clrBit = 1'b1;
          oeNext     = 1'b0;
          stNext     = ST_WDAT;
        end
        ST_RDAT: begin
          if (bitCnt == 4'd8) begin
            oeNext = 1'b0;
            stNext = ST_RACK;
          end else begin
            stb.shiftTx = 1'b1;
            oeNext      = ~txNext;
          end
        end
        ST_RACK: if (bitCnt == 4'd9) begin
          if (!rxByte[0]) begin
            stb.clrBit = 1'b1;
            stb.loadTx = 1'b1;
            oeNext     = ~memRdMsb;
            stNext     = ST_RDAT;
          end else begin
            oeNext = 1'b0;
            stNext = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      sdaOe  <= 1'b0;
      rdMode <= 1'b0;
    end else begin
      state  <= stNext;
      sdaOe  <= oeNext;
      rdMode <= rdNext;
    end
  end

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclSync));

  // R9
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> state != ST_DEV_ACK);

  // R3
  ignore_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IGNORE |-> !sdaOe);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && !startEv) |=> state == ST_IDLE);

endmodule

// File: rtl/smem_store.sv
`timescale 1ns/1ps
module smem_store #(
  parameter int STORE_AW    = 8,
  parameter int PROG_CYCLES = 600
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STORE_AW-1:0] rdIdx,
  output logic [7:0]          rdData,
  input  logic                commit,
  input  logic [STORE_AW-1:0] wrIdx,
  input  logic [7:0]          wrData,
  output logic                busy
);

  localparam int DEPTH = 1 << STORE_AW;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (commit) timer <= TW'(PROG_CYCLES);
    else if (timer != '0) timer <= timer - 1'b1;
  end

  assign rdData = mem[rdIdx];
  assign busy   = (timer != '0);

  // R5
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> busy);

endmodule

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
module serial_mem_slave
  import smem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int STORE_AW    = 8,
  parameter int PROG_CYCLES = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] csPins,
  output logic       sdaPullLow
);

  dpStrobe_t           stb;
  logic                startEv, stopEv, sclFall, sclSync;
  logic [3:0]          bitCnt;
  logic [7:0]          rxByte;
  logic                txNext;
  logic [STORE_AW-1:0] memIdx, wrIdx;
  logic [7:0]          memRdata, wrData;
  logic                wrValid, busy;

  smem_datapath #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .memRdata(memRdata), .startEv(startEv), .stopEv(stopEv),
    .sclFall(sclFall), .sclSync(sclSync), .bitCnt(bitCnt), .rxByte(rxByte),
    .txNext(txNext), .memIdx(memIdx), .wrValid(wrValid), .wrIdx(wrIdx),
    .wrData(wrData)
  );

  smem_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .sclFall(sclFall), .sclSync(sclSync), .bitCnt(bitCnt), .rxByte(rxByte),
    .txNext(txNext), .memRdMsb(memRdata[7]), .wrValid(wrValid), .busy(busy),
    .csPins(csPins), .stb(stb), .sdaOe(sdaPullLow)
  );

  smem_store #(.STORE_AW(STORE_AW), .PROG_CYCLES(PROG_CYCLES)) uStore (
    .clk(clk), .rstN(rstN), .rdIdx(memIdx), .rdData(memRdata),
    .commit(stb.commit), .wrIdx(wrIdx), .wrData(wrData), .busy(busy)
  );

endmodule

// File: tb/sim_serial_mem_slave.sv
`timescale 1ns/1ps
module sim_serial_mem_slave;

  localparam int Q = 6;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, CS, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, CS, 1'b1};
  // {address[12:0], data[7:0]}
  localparam logic [20:0] VEC [9] = '{
    21'h0010A5, 21'h00116E, 21'h1F033C, 21'h0A7F81, 21'h00FEC7,
    21'h1234FF, 21'h05555A, 21'h1FFF99, 21'h10004B
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic masterLow = 1'b0;
  logic dutLow;
  logic sdaLine;
  logic [7:0] model [256];
  int total = 0;
  int fails = 0;

  assign sdaLine = !(masterLow || dutLow);

  serial_mem_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .csPins(CS), .sdaPullLow(dutLow)
  );

  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    masterLow = 1'b0; tick(Q);
    scl = 1'b1;       tick(Q);
    masterLow = 1'b1; tick(Q);
    scl = 1'b0;       tick(Q);
  endtask

  task automatic stopCond();
    masterLow = 1'b1; tick(Q);
    scl = 1'b1;       tick(Q);
    masterLow = 1'b0; tick(Q);
    tick(Q);
  endtask

  task automatic clockBit(input logic d, output logic s);
    masterLow = !d; tick(Q);
    scl = 1'b1;     tick(Q);
    s = sdaLine;    tick(Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = !s;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      b = {b[6:0], s};
    end
    clockBit(!ackIt, s);
  endtask

  task automatic setAddr(input logic [12:0] a, output logic ok);
    logic k0, k1, k2;
    startCond();
    writeByte(SEL_W, k0);
    writeByte({3'b000, a[12:8]}, k1);
    writeByte(a[7:0], k2);
    ok = k0 & k1 & k2;
  endtask

  task automatic rndRead(input logic [12:0] a, output logic [7:0] d, output logic ok);
    logic k0, k1;
    setAddr(a, k0);
    startCond();
    writeByte(SEL_R, k1);
    readByte(1'b0, d);
    stopCond();
    ok = k0 & k1;
  endtask

  task automatic curRead(output logic [7:0] d, output logic ok);
    startCond();
    writeByte(SEL_R, ok);
    readByte(1'b0, d);
    stopCond();
  endtask

  // one poll: select, and if accepted finish the transfer cleanly
  task automatic pollOnce(input logic [7:0] sel, output logic ack);
    logic [7:0] dummy;
    startCond();
    writeByte(sel, ack);
    if (ack && sel[0]) readByte(1'b0, dummy);
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic k, ok;
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;

    tick(5);
    check("R11 line released in reset", {31'd0, dutLow}, 32'd0);
    rstN = 1'b1;
    tick(5);
    check("R11 line released after reset", {31'd0, dutLow}, 32'd0);

    // table of byte writes, each polled and read back
    for (int i = 0; i < 9; i++) begin
      logic [12:0] a;
      logic [7:0] d, sel;
      logic k0, k3, okA;
      int polls;
      a = VEC[i][20:8];
      d = VEC[i][7:0];
      setAddr(a, okA);
      writeByte(d, k3);
      stopCond();
      check("R2 R4 select and address acknowledged", {31'd0, okA}, 32'd1);
      check("R5 data byte acknowledged", {31'd0, k3}, 32'd1);
      model[a[7:0]] = d;
      sel = (i % 2 == 1) ? SEL_R : SEL_W;
      pollOnce(sel, k0);
      check("R9 select refused while programming", {31'd0, k0}, 32'd0);
      polls = 0;
      while (!k0 && polls < 20) begin
        pollOnce(sel, k0);
        polls++;
      end
      check("R9 select accepted after programming", {31'd0, k0}, 32'd1);
      rndRead(a, rd, ok);
      check("R6 random read acknowledged", {31'd0, ok}, 32'd1);
      check("R6 R10 random read data", {24'd0, rd}, {24'd0, d});
    end

    // R7: current-address read continues after a random read
    rndRead(13'h0010, rd, ok);
    check("R6 random read before current read", {24'd0, rd}, {24'd0, model[8'h10]});
    curRead(rd, ok);
    check("R7 current read acknowledged", {31'd0, ok}, 32'd1);
    check("R7 current read data", {24'd0, rd}, {24'd0, model[8'h11]});
    curRead(rd, ok);
    check("R7 counter advanced again", {24'd0, rd}, {24'd0, model[8'h12]});

    // R8: sequential read wrapping from the top address
    setAddr(13'h1FFE, ok);
    startCond();
    writeByte(SEL_R, k);
    check("R8 read select acknowledged", {31'd0, ok & k}, 32'd1);
    readByte(1'b1, rd);
    check("R8 byte at 8190", {24'd0, rd}, {24'd0, model[8'hFE]});
    readByte(1'b1, rd);
    check("R8 byte at 8191", {24'd0, rd}, {24'd0, model[8'hFF]});
    readByte(1'b1, rd);
    check("R8 wrap to address 0", {24'd0, rd}, {24'd0, model[8'h00]});
    readByte(1'b0, rd);
    check("R8 byte at address 1", {24'd0, rd}, {24'd0, model[8'h01]});
    stopCond();
    check("R8 line released after no-acknowledge", {31'd0, dutLow}, 32'd0);

    // R3: strap mismatch, then bytes without a START stay ignored
    startCond();
    writeByte({4'b1010, 3'b010, 1'b0}, k);
    check("R3 mismatched select refused", {31'd0, k}, 32'd0);
    writeByte(SEL_W, k);
    check("R3 later byte ignored until START", {31'd0, k}, 32'd0);
    writeByte({4'b0110, CS, 1'b0}, k);
    stopCond();
    startCond();
    writeByte(SEL_W, k);
    check("R1 fresh START decodes select", {31'd0, k}, 32'd1);
    stopCond();

    // R6: repeated START after data drops the write
    setAddr(13'h0034, ok);
    writeByte(8'h11, k);
    startCond();
    writeByte(SEL_R, k);
    check("R6 no programming after repeated START", {31'd0, k}, 32'd1);
    readByte(1'b0, rd);
    stopCond();
    rndRead(13'h0034, rd, ok);
    check("R6 dropped write left store unchanged", {24'd0, rd}, {24'd0, model[8'h34]});

    // R1: STOP after address only programs nothing
    setAddr(13'h0055, ok);
    stopCond();
    startCond();
    writeByte(SEL_W, k);
    check("R1 STOP without data leaves engine ready", {31'd0, k}, 32'd1);
    stopCond();
    rndRead(13'h0055, rd, ok);
    check("R1 store unchanged after address-only STOP", {24'd0, rd}, {24'd0, model[8'h55]});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule